// File: doc/BRIEF.md
# Mailbox Command Bridge to Byte-Wide Controller Registers

This block gives a 64-bit host register window access to a small bank of 8-bit controller registers through a single command word. The host writes the whole word: a busy flag, a direction flag, two operation bits, a register selector and a data byte. The bridge holds the word and performs the internal access after a fixed latency. It then drops the busy flag. A read also replaces the low byte of the word with the fetched value. Software polls the word until the flag is clear.

The internal bank is a stub of the controller it fronts. It has a data byte, a control byte, a clock divider setting, a status byte and a clock high-period count. One selector code is asymmetric: a write to it lands in the divider setting, while a read of it returns the status byte. A soft-reset selector puts the status back to its idle code. The two clock settings are driven out as ports toward the serial engine, which is not part of this block.

Top module: `mbox_reg_bridge`

## Requirements
- R1: After reset the command word reads all zeros, both clock outputs are zero and the status byte holds the idle code 0xF8.
- R2: A host write while bit 63 of the command word is clear stores the full 64-bit word in the next cycle. Bit 63 set in the written word starts an internal access.
- R3: A host write that arrives while bit 63 is set leaves the command word and every register unchanged.
- R4: Bit 63 clears exactly LATENCY cycles (default 2) after the cycle in which the starting write was accepted.
- R5: Bit 56 set means a read. On completion, bits 7:0 take the fetched byte and bits 62:8 keep their values. For a write, bits 62:0 are unchanged.
- R6: With bits 59 and 58 both set, selector bits 34:32 equal to 1 write or read the data byte, and 2 write or read the control byte.
- R7: With bits 59 and 58 set and selector 3, a write loads the divider setting (seen on `clk_div_cfg`) and leaves status alone. A read returns the status byte.
- R8: Bit 59 set with bit 58 clear addresses the high-period count. A write drives `clk_hi_period`, and a read returns the count.
- R9: A write with bits 59 and 58 set and selector 7 returns the status byte to 0xF8 and clears the control byte.
- R10: A control write whose data bit 5 is set moves the status byte to 0x08.
- R11: A word written with bit 63 clear is stored but performs no access. No register changes.
- R12: An extended access with any selector other than 1, 2, 3 or 7 changes no register, and a read of it returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| host_wr_en | input | 1 | Host write strobe for the command word |
| host_wdata | input | 64 | Command word from the host |
| host_rdata | output | 64 | Current command word (busy flag, fields, read result) |
| clk_hi_period | output | 8 | High-period count toward the serial engine |
| clk_div_cfg | output | 8 | Divider setting toward the serial engine |

## Verification
The checker watches several rules on every cycle. Idle writes are captured whole, and the word is frozen while busy outside the completion cycle. The busy time is counted against LATENCY. A read keeps bits 62:8, a soft reset produces the idle status, and a start-bit control write produces the start status. Only the bench scenarios can show which register a given selector and direction reach. They also show that the asymmetric selector reads status after a divider write, and that inert words and unsupported selectors leave the data byte intact when it is read back later. A behavioural model in the bench, compared on every clock, covers the full word and both clock outputs.

// File: rtl/mbox_pkg.sv
`timescale 1ns/1ps
package mbox_pkg;
  localparam int WORD_W    = 64;
  localparam int BYTE_W    = 8;
  localparam int SEL_W     = 3;
  localparam int BIT_BUSY  = 63;
  localparam int BIT_OPHI  = 59;
  localparam int BIT_OPLO  = 58;
  localparam int BIT_RD    = 56;
  localparam int SEL_LSB   = 32;
  localparam int CTRL_START_BIT = 5;

  localparam logic [BYTE_W-1:0] STAT_IDLE  = 8'hF8;
  localparam logic [BYTE_W-1:0] STAT_START = 8'h08;

  localparam logic [SEL_W-1:0] SEL_DATA  = 3'd1;
  localparam logic [SEL_W-1:0] SEL_CTRL  = 3'd2;
  localparam logic [SEL_W-1:0] SEL_CLKST = 3'd3;
  localparam logic [SEL_W-1:0] SEL_SRST  = 3'd7;

  typedef enum logic [2:0] {
    TGT_NONE  = 3'd0,
    TGT_DATA  = 3'd1,
    TGT_CTRL  = 3'd2,
    TGT_CLKST = 3'd3,
    TGT_SRST  = 3'd4,
    TGT_HIPER = 3'd5
  } tgt_e;

  typedef struct packed {
    logic              rd;
    tgt_e              tgt;
    logic [BYTE_W-1:0] wbyte;
  } acc_s;
endpackage

// File: rtl/mbox_rst_sync.sv
`timescale 1ns/1ps
module mbox_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/mbox_cmd_decode.sv
`timescale 1ns/1ps
module mbox_cmd_decode
  import mbox_pkg::*;
(
  input  logic              rd_bit,
  input  logic [1:0]        op_bits,
  input  logic [SEL_W-1:0]  sel,
  input  logic [BYTE_W-1:0] byte_in,
  output acc_s              acc
);
  logic ext_op;
  logic hiper_op;

  assign ext_op   = op_bits[1] & op_bits[0];
  assign hiper_op = op_bits[1] & ~op_bits[0];

  always_comb begin
    acc.rd    = rd_bit;
    acc.wbyte = byte_in;
    acc.tgt   = TGT_NONE;
    if (hiper_op) begin
      acc.tgt = TGT_HIPER;
    end else if (ext_op) begin
      case (sel)
        SEL_DATA:  acc.tgt = TGT_DATA;
        SEL_CTRL:  acc.tgt = TGT_CTRL;
        SEL_CLKST: acc.tgt = TGT_CLKST;
        SEL_SRST:  acc.tgt = TGT_SRST;
        default:   acc.tgt = TGT_NONE;
      endcase
    end
  end
endmodule

// File: rtl/mbox_seq.sv
`timescale 1ns/1ps
module mbox_seq
  import mbox_pkg::*;
#(
  parameter int LATENCY = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr_en,
  input  logic [WORD_W-1:0] host_wdata,
  input  logic              bus_ack,
  input  logic [BYTE_W-1:0] bus_rdata,
  output logic [WORD_W-1:0] cmd_q,
  output logic              bus_req
);
  localparam int CNT_W = $clog2(LATENCY + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(LATENCY);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(1);

  logic [WORD_W-1:0] cmd_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              busy;
  logic              accept;
  logic              finish;
  logic              cmd_en;
  logic              cnt_en;

  assign busy    = cmd_q[BIT_BUSY];
  assign bus_req = busy && (cnt_q == CNT_LAST);
  assign finish  = bus_req && bus_ack;
  assign accept  = !busy && host_wr_en;

  always_comb begin
    cmd_d = cmd_q;
    cnt_d = cnt_q;
    if (finish) begin
      cmd_d[BIT_BUSY] = 1'b0;
      if (cmd_q[BIT_RD]) cmd_d[BYTE_W-1:0] = bus_rdata;
      cnt_d = '0;
    end else if (busy) begin
      if (cnt_q > CNT_LAST) cnt_d = cnt_q - CNT_LAST;
    end else if (accept) begin
      cmd_d = host_wdata;
      cnt_d = host_wdata[BIT_BUSY] ? CNT_LOAD : '0;
    end
  end

  assign cmd_en = accept | finish;
  assign cnt_en = accept | finish | (busy && (cnt_q > CNT_LAST));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cmd_q <= '0;
    else if (cmd_en) cmd_q <= cmd_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/mbox_reg_stub.sv
`timescale 1ns/1ps
module mbox_reg_stub
  import mbox_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  acc_s              acc,
  output logic              ack,
  output logic [BYTE_W-1:0] rdata,
  output logic [BYTE_W-1:0] hi_period,
  output logic [BYTE_W-1:0] div_cfg,
  output logic [BYTE_W-1:0] status
);
  logic [BYTE_W-1:0] data_q, data_d;
  logic [BYTE_W-1:0] ctrl_q, ctrl_d;
  logic [BYTE_W-1:0] div_q,  div_d;
  logic [BYTE_W-1:0] hip_q,  hip_d;
  logic [BYTE_W-1:0] stat_q, stat_d;
  logic              wr_go;
  logic              data_en, ctrl_en, div_en, hip_en, stat_en;

  assign ack   = req;
  assign wr_go = req && !acc.rd;

  always_comb begin
    data_d  = data_q;
    ctrl_d  = ctrl_q;
    div_d   = div_q;
    hip_d   = hip_q;
    stat_d  = stat_q;
    data_en = 1'b0;
    ctrl_en = 1'b0;
    div_en  = 1'b0;
    hip_en  = 1'b0;
    stat_en = 1'b0;
    if (wr_go) begin
      case (acc.tgt)
        TGT_DATA: begin
          data_d  = acc.wbyte;
          data_en = 1'b1;
        end
        TGT_CTRL: begin
          ctrl_d  = acc.wbyte;
          ctrl_en = 1'b1;
          if (acc.wbyte[CTRL_START_BIT]) begin
            stat_d  = STAT_START;
            stat_en = 1'b1;
          end
        end
        TGT_CLKST: begin
          div_d  = acc.wbyte;
          div_en = 1'b1;
        end
        TGT_HIPER: begin
          hip_d  = acc.wbyte;
          hip_en = 1'b1;
        end
        TGT_SRST: begin
          stat_d  = STAT_IDLE;
          stat_en = 1'b1;
          ctrl_d  = '0;
          ctrl_en = 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    case (acc.tgt)
      TGT_DATA:  rdata = data_q;
      TGT_CTRL:  rdata = ctrl_q;
      TGT_CLKST: rdata = stat_q;
      TGT_HIPER: rdata = hip_q;
      default:   rdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       data_q <= '0;
    else if (data_en) data_q <= data_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (ctrl_en) ctrl_q <= ctrl_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      div_q <= '0;
    else if (div_en) div_q <= div_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      hip_q <= '0;
    else if (hip_en) hip_q <= hip_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       stat_q <= STAT_IDLE;
    else if (stat_en) stat_q <= stat_d;
  end

  assign hi_period = hip_q;
  assign div_cfg   = div_q;
  assign status    = stat_q;
endmodule

// File: rtl/mbox_reg_bridge.sv
`timescale 1ns/1ps
module mbox_reg_bridge
  import mbox_pkg::*;
#(
  parameter int LATENCY = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        host_wr_en,
  input  logic [63:0] host_wdata,
  output logic [63:0] host_rdata,
  output logic [7:0]  clk_hi_period,
  output logic [7:0]  clk_div_cfg
);
  logic              rst_sync_n;
  logic [WORD_W-1:0] cmd_q;
  logic              bus_req;
  logic              bus_ack;
  logic [BYTE_W-1:0] bus_rdata;
  logic [BYTE_W-1:0] stat_q;
  acc_s              acc;

  mbox_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  mbox_seq #(.LATENCY(LATENCY)) u_seq (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .host_wr_en (host_wr_en),
    .host_wdata (host_wdata),
    .bus_ack    (bus_ack),
    .bus_rdata  (bus_rdata),
    .cmd_q      (cmd_q),
    .bus_req    (bus_req)
  );

  mbox_cmd_decode u_dec (
    .rd_bit  (cmd_q[BIT_RD]),
    .op_bits (cmd_q[BIT_OPHI:BIT_OPLO]),
    .sel     (cmd_q[SEL_LSB+SEL_W-1:SEL_LSB]),
    .byte_in (cmd_q[BYTE_W-1:0]),
    .acc     (acc)
  );

  mbox_reg_stub u_regs (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .req       (bus_req),
    .acc       (acc),
    .ack       (bus_ack),
    .rdata     (bus_rdata),
    .hi_period (clk_hi_period),
    .div_cfg   (clk_div_cfg),
    .status    (stat_q)
  );

  assign host_rdata = cmd_q;
endmodule

// File: rtl/mbox_reg_bridge_chk.sv
`timescale 1ns/1ps
module mbox_reg_bridge_chk
  import mbox_pkg::*;
#(
  parameter int LATENCY = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              host_wr_en,
  input logic [WORD_W-1:0] host_wdata,
  input logic [WORD_W-1:0] cmd_q,
  input logic              bus_req,
  input acc_s              acc,
  input logic [BYTE_W-1:0] status
);
  logic [15:0] busy_cycles;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               busy_cycles <= '0;
    else if (cmd_q[BIT_BUSY]) busy_cycles <= busy_cycles + 16'd1;
    else                      busy_cycles <= '0;
  end

  // R2
  p_accept_word_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_q[BIT_BUSY] && host_wr_en) |=> (cmd_q == $past(host_wdata)));

  // R3
  p_busy_frozen_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q[BIT_BUSY] && !bus_req) |=> $stable(cmd_q));

  // R4
  p_latency_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cmd_q[BIT_BUSY]) |-> (busy_cycles == 16'(LATENCY)));

  // R4
  p_req_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> cmd_q[BIT_BUSY]);

  // R5
  p_read_keeps_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && acc.rd) |=> (cmd_q[62:8] == $past(cmd_q[62:8])));

  // R9
  p_srst_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !acc.rd && acc.tgt == TGT_SRST) |=> (status == STAT_IDLE));

  // R10
  p_start_stat_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !acc.rd && acc.tgt == TGT_CTRL && acc.wbyte[CTRL_START_BIT])
      |=> (status == STAT_START));
endmodule

bind mbox_reg_bridge mbox_reg_bridge_chk #(.LATENCY(LATENCY)) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .host_wr_en (host_wr_en),
  .host_wdata (host_wdata),
  .cmd_q      (cmd_q),
  .bus_req    (bus_req),
  .acc        (acc),
  .status     (stat_q)
);

// File: tb/test_mbox_reg_bridge.sv
`timescale 1ns/1ps
module test_mbox_reg_bridge;
  localparam int LAT = 2;

  logic        clk;
  logic        rst_n;
  logic        host_wr_en;
  logic [63:0] host_wdata;
  logic [63:0] host_rdata;
  logic [7:0]  clk_hi_period;
  logic [7:0]  clk_div_cfg;

  int n_vec;
  int n_bad;
  bit done;

  mbox_reg_bridge #(.LATENCY(LAT)) i_mbox_reg_bridge (
    .clk           (clk),
    .rst_n         (rst_n),
    .host_wr_en    (host_wr_en),
    .host_wdata    (host_wdata),
    .host_rdata    (host_rdata),
    .clk_hi_period (clk_hi_period),
    .clk_div_cfg   (clk_div_cfg)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // behavioural reference model
  logic [63:0] m_cmd;
  int          m_cnt;
  logic [7:0]  m_data, m_ctrl, m_div, m_hp, m_stat, m_r;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cmd = '0; m_cnt = 0; m_data = 0; m_ctrl = 0;
      m_div = 0; m_hp = 0; m_stat = 8'hF8;
    end else if (m_cmd[63]) begin
      if (m_cnt == 1) begin
        m_r = 8'h00;
        if (m_cmd[59] && m_cmd[58]) begin
          case (m_cmd[34:32])
            3'd1: if (m_cmd[56]) m_r = m_data; else m_data = m_cmd[7:0];
            3'd2: if (m_cmd[56]) m_r = m_ctrl;
                  else begin
                    m_ctrl = m_cmd[7:0];
                    if (m_cmd[5]) m_stat = 8'h08;
                  end
            3'd3: if (m_cmd[56]) m_r = m_stat; else m_div = m_cmd[7:0];
            3'd7: if (!m_cmd[56]) begin m_stat = 8'hF8; m_ctrl = 8'h00; end
            default: ;
          endcase
        end else if (m_cmd[59]) begin
          if (m_cmd[56]) m_r = m_hp; else m_hp = m_cmd[7:0];
        end
        if (m_cmd[56]) m_cmd[7:0] = m_r;
        m_cmd[63] = 1'b0;
        m_cnt = 0;
      end else begin
        m_cnt = m_cnt - 1;
      end
    end else if (host_wr_en) begin
      m_cmd = host_wdata;
      m_cnt = host_wdata[63] ? LAT : 0;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      n_vec++;
      if (host_rdata !== m_cmd) begin
        n_bad++;
        $display("FAIL R2 command word: actual %h expected %h", host_rdata, m_cmd);
      end
      if (clk_hi_period !== m_hp) begin
        n_bad++;
        $display("FAIL R8 hi period: actual %h expected %h", clk_hi_period, m_hp);
      end
      if (clk_div_cfg !== m_div) begin
        n_bad++;
        $display("FAIL R7 divider: actual %h expected %h", clk_div_cfg, m_div);
      end
    end
  end

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] ext_cmd(input bit rd, input logic [2:0] sel, input logic [7:0] b);
    return (64'h1 << 63) | (64'h3 << 58) | (64'(rd) << 56) | (64'(sel) << 32) | 64'(b);
  endfunction

  function automatic logic [63:0] hp_cmd(input bit rd, input logic [7:0] b);
    return (64'h1 << 63) | (64'h1 << 59) | (64'(rd) << 56) | 64'(b);
  endfunction

  task automatic issue(input logic [63:0] w, output logic [63:0] res, output int cyc);
    @(negedge clk);
    host_wr_en = 1'b1;
    host_wdata = w;
    @(negedge clk);
    host_wr_en = 1'b0;
    cyc = 0;
    while (host_rdata[63]) begin
      cyc++;
      @(negedge clk);
    end
    res = host_rdata;
  endtask

  task automatic rd_byte(input logic [63:0] w, output logic [7:0] b);
    logic [63:0] res;
    int cyc;
    issue(w, res, cyc);
    b = res[7:0];
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_bad++;
    $display("FAIL R4 watchdog expired: actual hung expected completion");
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    logic [63:0] res, w;
    logic [7:0]  b;
    int cyc;
    n_vec = 0; n_bad = 0; done = 1'b0;
    host_wr_en = 1'b0; host_wdata = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    check("R1 word after reset", host_rdata, 64'h0);
    check("R1 clocks after reset", {48'h0, clk_hi_period, clk_div_cfg}, 64'h0);
    rd_byte(ext_cmd(1, 3'd3, 8'h00), b);
    check("R1 idle status", 64'(b), 64'hF8);

    w = ext_cmd(0, 3'd1, 8'hA5);
    issue(w, res, cyc);
    check("R4 write latency", 64'(cyc), 64'(LAT));
    check("R5 write keeps word", res, w & ~(64'h1 << 63));
    w = ext_cmd(1, 3'd1, 8'h3C) | (64'h5A << 40);
    issue(w, res, cyc);
    check("R4 read latency", 64'(cyc), 64'(LAT));
    check("R5 read word", res, (w & ~(64'h1 << 63) & ~64'hFF) | 64'hA5);
    check("R6 data byte", 64'(res[7:0]), 64'hA5);

    issue(ext_cmd(0, 3'd2, 8'h40), res, cyc);
    rd_byte(ext_cmd(1, 3'd2, 8'h00), b);
    check("R6 control byte", 64'(b), 64'h40);

    // R3: second write while busy must be dropped
    w = ext_cmd(1, 3'd1, 8'h00);
    @(negedge clk);
    host_wr_en = 1'b1; host_wdata = w;
    @(negedge clk);
    host_wdata = ext_cmd(0, 3'd1, 8'h99);
    @(negedge clk);
    host_wr_en = 1'b0;
    while (host_rdata[63]) @(negedge clk);
    check("R3 busy write ignored word", host_rdata, (w & ~(64'h1 << 63)) | 64'hA5);
    rd_byte(ext_cmd(1, 3'd1, 8'h00), b);
    check("R3 data untouched", 64'(b), 64'hA5);

    issue(ext_cmd(0, 3'd3, 8'h13), res, cyc);
    check("R7 divider written", 64'(clk_div_cfg), 64'h13);
    rd_byte(ext_cmd(1, 3'd3, 8'h00), b);
    check("R7 selector 3 reads status", 64'(b), 64'hF8);

    issue(hp_cmd(0, 8'h2C), res, cyc);
    check("R8 hi period out", 64'(clk_hi_period), 64'h2C);
    rd_byte(hp_cmd(1, 8'h00), b);
    check("R8 hi period read", 64'(b), 64'h2C);

    issue(ext_cmd(0, 3'd2, 8'h60), res, cyc);
    rd_byte(ext_cmd(1, 3'd3, 8'h00), b);
    check("R10 start status", 64'(b), 64'h08);

    issue(ext_cmd(0, 3'd7, 8'h00), res, cyc);
    rd_byte(ext_cmd(1, 3'd3, 8'h00), b);
    check("R9 status idle", 64'(b), 64'hF8);
    rd_byte(ext_cmd(1, 3'd2, 8'h00), b);
    check("R9 control cleared", 64'(b), 64'h00);

    w = ext_cmd(0, 3'd1, 8'h11) & ~(64'h1 << 63);
    issue(w, res, cyc);
    check("R11 inert word stored", res, w);
    check("R11 no busy time", 64'(cyc), 64'h0);
    rd_byte(ext_cmd(1, 3'd1, 8'h00), b);
    check("R11 data unchanged", 64'(b), 64'hA5);

    issue(ext_cmd(0, 3'd5, 8'h77), res, cyc);
    rd_byte(ext_cmd(1, 3'd5, 8'h00), b);
    check("R12 unsupported reads zero", 64'(b), 64'h00);
    rd_byte(ext_cmd(1, 3'd1, 8'h00), b);
    check("R12 data unchanged", 64'(b), 64'hA5);
    check("R12 clocks unchanged", {48'h0, clk_hi_period, clk_div_cfg}, 64'h2C13);

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule